// File: doc/BRIEF.md
# Synchronous Serial Shift Channel

This block is a full-duplex synchronous serial shift unit that runs either as the clock master or as a clocked slave. Software supplies the transfer settings: clock idle level, clock phase, bit order and word width. A write strobe loads a word into the shift register. From then on the unit sends that word while it receives a word of the same length. When the last bit is in, the received word moves to a receive buffer and a receive flag is raised.

As master, the unit advances one half bit period on each pulse of an external baud tick. It drives the serial clock and the data output itself. As slave, it follows an external serial clock, which passes through a two-flop synchronizer and an edge detector first. A slave puts its first bit on the data line as soon as its shift register is loaded, so the bit is valid before the master's first edge.

Each serial output pin is the AND of an internal output and a port latch bit. The internal output is held at 1 while the unit is disabled. Between transfers, a master's clock rests at the programmed idle level and its data line keeps the last bit it sent.

Top module: `syncSerialChan`

## Requirements
- R1: The width code c on `wCode` gives a transfer of c+1 bits, and code 0 gives 2 bits. Received words are right-aligned in `rxData`, and the bits above the width read 0. Transmit bits above the width are never sent.
- R2: With `lsbFirst` = 0 the word is shifted out and in MSB first. With `lsbFirst` = 1 it is shifted LSB first. Both directions use the same order.
- R3: In master mode, a `txWrite` while enabled and idle loads the shift register and raises `busy` the next cycle. A transfer of N bits takes 2N+1 baud ticks when `cpha` = 0: the first tick only places bit 0 on `sdoOut`. It takes 2N ticks when `cpha` = 1: bit 0 is placed together with the first clock edge.
- R4: The master's leading clock edge moves `sclkOut` away from `cpol` and the trailing edge returns it to `cpol`. With `cpha` = 0 the master samples `sdiIn` on leading edges and changes `sdoOut` on trailing edges. With `cpha` = 1 it changes `sdoOut` on leading edges and samples on trailing edges. Send and receive always happen together.
- R5: In slave mode, `sdoOut` shows the first bit of the loaded word in the cycle after the load, before any clock edge. The slave shifts on edges of the synchronized `sclkIn`, following the same phase rules as R4.
- R6: On the cycle that ends a transfer, `rxData` takes the received word, `rxFlag` is set and `busy` falls, all together. `rxData` changes at no other time.
- R7: `flagClr` clears `rxFlag` and `txErr`. If a transfer ends in the same cycle as `flagClr`, `rxFlag` stays set.
- R8: A `txWrite` while busy sets `txErr`. The running transfer continues unchanged, with its original transmit and receive words.
- R9: While an enabled master is idle, `sclkOut` sits at `cpol`. After a transfer, `sdoOut` keeps the last bit sent.
- R10: While `enable` is 0 the internal outputs are 1 and `txWrite` has no effect (`busy` stays 0). At all times `sdoOut` is the internal data output AND `dataLatch`, and `sclkOut` is the internal clock output AND `clkLatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Unit enable |
| masterMode | input | 1 | 1 = master, 0 = slave |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | 0 = sample on leading edge, 1 = sample on trailing edge |
| lsbFirst | input | 1 | 0 = MSB first, 1 = LSB first |
| wCode | input | 4 | Width code, bits = code+1 (code 0 means 2) |
| txWrite | input | 1 | Transmit buffer write strobe |
| txData | input | 16 | Word to transmit |
| flagClr | input | 1 | Clears the receive and error flags |
| baudTick | input | 1 | Half-bit tick from the baud generator (master) |
| sclkIn | input | 1 | External serial clock (slave) |
| sdiIn | input | 1 | Serial data input |
| clkLatch | input | 1 | Port latch bit ANDed into the clock pin |
| dataLatch | input | 1 | Port latch bit ANDed into the data pin |
| sclkOut | output | 1 | Serial clock pin value |
| sdoOut | output | 1 | Serial data pin value |
| rxData | output | 16 | Receive buffer |
| rxFlag | output | 1 | Receive complete flag |
| txErr | output | 1 | Write-while-busy flag |
| busy | output | 1 | Transfer in progress |

## Verification
The end of a transfer and a software flag clear can land in the same clock cycle. The bench provokes this by asserting `flagClr` together with the final baud tick of a master transfer. It then expects `rxFlag` to remain set, with the new word in `rxData`, and a lone `flagClr` afterwards must clear it. A second overlap puts a transmit write on the same cycle as a tick of a running transfer. That write must only raise `txErr`, and the bits seen on the line and the word received must be those of the original transfer.

// File: rtl/syncSerialPkg.sv
package syncSerialPkg;

  typedef struct packed {
    logic load;
    logic drive;
    logic sample;
    logic done;
  } dpStrobes_t;

endpackage

// File: rtl/syncSerialCtl.sv
module syncSerialCtl
  import syncSerialPkg::*;
#(
  parameter int DW = 16,
  localparam int CW = $clog2(DW),
  localparam int TW = $clog2(2 * DW + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          masterMode,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [CW-1:0] wCode,
  input  logic          txWrite,
  input  logic          flagClr,
  input  logic          baudTick,
  input  logic          sclkIn,
  output dpStrobes_t    strb,
  output logic [CW:0]   numBits,
  output logic          sclkReg,
  output logic          busy,
  output logic          rxFlag,
  output logic          txErr
);

  logic [TW-1:0] tickCnt, nextTick, lastTick;
  logic [CW:0]   bitCnt;
  logic          sync1, sync2, sync3;
  logic          syncEdge;
  logic          leadEv, trailEv, tickEv, errSet, abortXfer;

  always_comb begin
    numBits  = (wCode == '0) ? (CW+1)'(2) : ({1'b0, wCode} + (CW+1)'(1));
    lastTick = TW'({numBits, 1'b0}) + TW'(!cpha);
    nextTick = tickCnt + TW'(1);
    syncEdge = sync2 ^ sync3;
    errSet   = txWrite && busy;
    abortXfer = busy && !enable;
  end

  always_comb begin
    strb      = '0;
    leadEv    = 1'b0;
    trailEv   = 1'b0;
    tickEv    = 1'b0;
    strb.load = txWrite && enable && !busy;
    if (busy && enable && masterMode && baudTick) begin
      tickEv = 1'b1;
      if (!cpha) begin
        if (nextTick == TW'(1)) begin
          strb.drive = 1'b1;
        end else if (!nextTick[0]) begin
          leadEv      = 1'b1;
          strb.sample = 1'b1;
        end else begin
          trailEv = 1'b1;
          if (nextTick != lastTick) strb.drive = 1'b1;
        end
      end else begin
        if (nextTick[0]) begin
          leadEv     = 1'b1;
          strb.drive = 1'b1;
        end else begin
          trailEv     = 1'b1;
          strb.sample = 1'b1;
        end
      end
      if (nextTick == lastTick) strb.done = 1'b1;
    end else if (busy && enable && !masterMode && syncEdge) begin
      if (sync2 != cpol) leadEv = 1'b1;
      else               trailEv = 1'b1;
      if (cpha) begin
        strb.drive  = leadEv;
        strb.sample = trailEv;
      end else begin
        strb.sample = leadEv;
        strb.drive  = trailEv;
      end
      if (strb.sample && (bitCnt == numBits - (CW+1)'(1))) strb.done = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      bitCnt  <= '0;
      sclkReg <= 1'b0;
      rxFlag  <= 1'b0;
      txErr   <= 1'b0;
      sync1   <= 1'b0;
      sync2   <= 1'b0;
      sync3   <= 1'b0;
    end else begin
      sync1 <= sclkIn;
      sync2 <= sync1;
      sync3 <= sync2;

      if (abortXfer)      busy <= 1'b0;
      else if (strb.load) busy <= 1'b1;
      else if (strb.done) busy <= 1'b0;

      if (strb.load)   tickCnt <= '0;
      else if (tickEv) tickCnt <= nextTick;

      if (strb.load)        bitCnt <= '0;
      else if (strb.sample) bitCnt <= bitCnt + (CW+1)'(1);

      if (!(busy && masterMode)) sclkReg <= cpol;
      else if (leadEv)           sclkReg <= ~cpol;
      else if (trailEv)          sclkReg <= cpol;

      if (strb.done)    rxFlag <= 1'b1;
      else if (flagClr) rxFlag <= 1'b0;

      if (errSet)       txErr <= 1'b1;
      else if (flagClr) txErr <= 1'b0;
    end
  end

  // R8: a write during a transfer raises the error flag
  a_r8_busy_write_err: assert property (@(posedge clk) disable iff (!rstN)
    (busy && txWrite) |=> txErr);

  // R6: completion sets the flag and frees the unit
  a_r6_done_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strb.done && enable) |=> (rxFlag && !busy));

  // R9: an idle master rests its clock at the idle level
  a_r9_clk_idle: assert property (@(posedge clk) disable iff (!rstN)
    (masterMode && !busy && $past(!busy) && $stable(cpol) && $stable(masterMode))
      |-> (sclkReg == cpol));

endmodule

// File: rtl/syncSerialDp.sv
module syncSerialDp
  import syncSerialPkg::*;
#(
  parameter int DW = 16,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobes_t    strb,
  input  logic          masterMode,
  input  logic          lsbFirst,
  input  logic [CW:0]   numBits,
  input  logic [DW-1:0] txData,
  input  logic          sdiIn,
  output logic          sdoReg,
  output logic [DW-1:0] rxBuf
);

  logic [DW-1:0] shiftReg, widthMask, shifted;
  logic [CW-1:0] topIdx;
  logic          outBit, firstBit;

  always_comb begin
    topIdx = CW'(numBits - (CW+1)'(1));
    for (int i = 0; i < DW; i++) widthMask[i] = (i < int'(numBits));
    outBit   = lsbFirst ? shiftReg[0] : shiftReg[topIdx];
    firstBit = lsbFirst ? txData[0]   : txData[topIdx];
    if (lsbFirst) begin
      shifted         = shiftReg >> 1;
      shifted[topIdx] = sdiIn;
    end else begin
      shifted    = (shiftReg << 1) & widthMask;
      shifted[0] = sdiIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoReg   <= 1'b1;
      rxBuf    <= '0;
    end else begin
      if (strb.load) begin
        shiftReg <= txData & widthMask;
        if (!masterMode) sdoReg <= firstBit;
      end else begin
        if (strb.sample) shiftReg <= shifted;
        if (strb.drive)  sdoReg   <= outBit;
      end
      if (strb.done) rxBuf <= strb.sample ? shifted : shiftReg;
    end
  end

  // R6: the receive buffer only changes on completion
  a_r6_rx_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.done |=> $stable(rxBuf));

endmodule

// File: rtl/syncSerialChan.sv
module syncSerialChan
  import syncSerialPkg::*;
#(
  parameter int DW = 16,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          masterMode,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsbFirst,
  input  logic [CW-1:0] wCode,
  input  logic          txWrite,
  input  logic [DW-1:0] txData,
  input  logic          flagClr,
  input  logic          baudTick,
  input  logic          sclkIn,
  input  logic          sdiIn,
  input  logic          clkLatch,
  input  logic          dataLatch,
  output logic          sclkOut,
  output logic          sdoOut,
  output logic [DW-1:0] rxData,
  output logic          rxFlag,
  output logic          txErr,
  output logic          busy
);

  dpStrobes_t  strb;
  logic [CW:0] numBits;
  logic        sclkReg, sdoReg, sclkInt, sdoInt;

  syncSerialCtl #(.DW(DW)) ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .cpol(cpol), .cpha(cpha), .wCode(wCode), .txWrite(txWrite),
    .flagClr(flagClr), .baudTick(baudTick), .sclkIn(sclkIn),
    .strb(strb), .numBits(numBits), .sclkReg(sclkReg), .busy(busy),
    .rxFlag(rxFlag), .txErr(txErr)
  );

  syncSerialDp #(.DW(DW)) dp (
    .clk(clk), .rstN(rstN), .strb(strb), .masterMode(masterMode),
    .lsbFirst(lsbFirst), .numBits(numBits), .txData(txData),
    .sdiIn(sdiIn), .sdoReg(sdoReg), .rxBuf(rxData)
  );

  always_comb begin
    sdoInt  = enable ? sdoReg : 1'b1;
    sclkInt = (enable && masterMode) ? sclkReg : 1'b1;
    sdoOut  = sdoInt & dataLatch;
    sclkOut = sclkInt & clkLatch;
  end

  // R10: a disabled unit passes the port latches straight to the pins
  a_r10_disabled_pins: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (sdoOut == dataLatch && sclkOut == clkLatch));

endmodule

// File: tb/syncSerialChan_test.sv
module syncSerialChan_test;

  logic clk = 1'b0;
  logic rstN, enable, masterMode, cpol, cpha, lsbFirst;
  logic [3:0] wCode;
  logic txWrite, flagClr, baudTick, sclkIn, sdiIn, clkLatch, dataLatch;
  logic [15:0] txData;
  logic sclkOut, sdoOut, rxFlag, txErr, busy;
  logic [15:0] rxData;

  int checks = 0;
  int fails = 0;
  logic [15:0] expQ[$];
  logic prevBusy = 1'b0;

  always #5 clk = ~clk;

  syncSerialChan uut (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .cpol(cpol), .cpha(cpha), .lsbFirst(lsbFirst), .wCode(wCode),
    .txWrite(txWrite), .txData(txData), .flagClr(flagClr),
    .baudTick(baudTick), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .clkLatch(clkLatch), .dataLatch(dataLatch), .sclkOut(sclkOut),
    .sdoOut(sdoOut), .rxData(rxData), .rxFlag(rxFlag), .txErr(txErr),
    .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbits(input logic [3:0] code);
    return (code == 4'd0) ? 2 : int'(code) + 1;
  endfunction

  function automatic logic [15:0] wmask(input int n);
    logic [15:0] m = '0;
    for (int i = 0; i < n; i++) m[i] = 1'b1;
    return m;
  endfunction

  // bit i in line order under R2
  function automatic logic lineBit(input logic [15:0] w, input int i,
                                   input int n, input logic lsb);
    return lsb ? w[i] : w[n-1-i];
  endfunction

  // scoreboard monitor: R6, R1
  always @(negedge clk) begin
    if (rstN && prevBusy && !busy) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 unexpected completion", rxData, 0);
      end else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(rxData == e, "R6/R1 received word", rxData, e);
        chk(rxFlag == 1'b1, "R6 flag at completion", rxFlag, 1);
      end
    end
    prevBusy = busy;
  end

  task automatic setup(input logic m, input logic pol, input logic ph,
                       input logic lsb, input logic [3:0] code);
    @(negedge clk);
    masterMode = m; cpol = pol; cpha = ph; lsbFirst = lsb; wCode = code;
    sclkIn = pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic waitLvl(input logic lvl);
    do @(negedge clk); while (sclkOut !== lvl);
  endtask

  task automatic masterXfer(input logic [15:0] tw, input logic [15:0] sw,
                            input bit doErr, input bit clrLast);
    int n, total;
    logic [15:0] gotW;
    n = nbits(wCode);
    total = cpha ? 2 * n : 2 * n + 1;
    gotW = '0;
    expQ.push_back(sw & wmask(n));
    @(negedge clk);
    if (!cpha) sdiIn = lineBit(sw, 0, n, lsbFirst);
    txWrite = 1'b1; txData = tw;
    @(negedge clk);
    txWrite = 1'b0;
    chk(busy == 1'b1, "R3 busy after load", busy, 1);
    fork
      begin
        for (int k = 1; k <= total; k++) begin
          repeat (3) @(negedge clk);
          baudTick = 1'b1;
          if (k == total && clrLast) flagClr = 1'b1;
          if (doErr && k == 3) begin txWrite = 1'b1; txData = ~tw; end
          @(negedge clk);
          baudTick = 1'b0; flagClr = 1'b0; txWrite = 1'b0;
          if (doErr && k == 3) chk(txErr == 1'b1, "R8 error on busy write", txErr, 1);
        end
      end
      begin
        for (int i = 0; i < n; i++) begin
          if (!cpha) begin
            waitLvl(~cpol);
            if (lsbFirst) gotW[i] = sdoOut; else gotW[n-1-i] = sdoOut;
            waitLvl(cpol);
            if (i < n - 1) sdiIn = lineBit(sw, i + 1, n, lsbFirst);
          end else begin
            waitLvl(~cpol);
            sdiIn = lineBit(sw, i, n, lsbFirst);
            waitLvl(cpol);
            if (lsbFirst) gotW[i] = sdoOut; else gotW[n-1-i] = sdoOut;
          end
        end
      end
    join
    chk(busy == 1'b0, "R3 done after tick count", busy, 0);
    chk(gotW == (tw & wmask(n)), "R4/R2 master line bits", gotW, tw & wmask(n));
    @(negedge clk);
    chk(sdoOut == lineBit(tw, n - 1, n, lsbFirst), "R9 data holds last bit",
        sdoOut, lineBit(tw, n - 1, n, lsbFirst));
    chk(sclkOut == cpol, "R9 idle clock level", sclkOut, cpol);
  endtask

  task automatic slaveXfer(input logic [15:0] tw, input logic [15:0] mw);
    int n;
    logic [15:0] gotW;
    n = nbits(wCode);
    gotW = '0;
    expQ.push_back(mw & wmask(n));
    @(negedge clk);
    txWrite = 1'b1; txData = tw;
    @(negedge clk);
    txWrite = 1'b0;
    chk(sdoOut == lineBit(tw, 0, n, lsbFirst), "R5 first bit before clock",
        sdoOut, lineBit(tw, 0, n, lsbFirst));
    for (int i = 0; i < n; i++) begin
      if (!cpha) begin
        sdiIn = lineBit(mw, i, n, lsbFirst);
        repeat (4) @(negedge clk);
        if (lsbFirst) gotW[i] = sdoOut; else gotW[n-1-i] = sdoOut;
        sclkIn = ~cpol;
        repeat (8) @(negedge clk);
        sclkIn = cpol;
        repeat (8) @(negedge clk);
      end else begin
        sclkIn = ~cpol;
        repeat (4) @(negedge clk);
        sdiIn = lineBit(mw, i, n, lsbFirst);
        repeat (4) @(negedge clk);
        if (lsbFirst) gotW[i] = sdoOut; else gotW[n-1-i] = sdoOut;
        sclkIn = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R5 slave transfer complete", busy, 0);
    chk(gotW == (tw & wmask(n)), "R5/R2 slave line bits", gotW, tw & wmask(n));
    chk(sdoOut == lineBit(tw, n - 1, n, lsbFirst), "R9 slave holds last bit",
        sdoOut, lineBit(tw, n - 1, n, lsbFirst));
  endtask

  task automatic clearFlags;
    @(negedge clk);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    chk(rxFlag == 1'b0, "R7 clear strobe", rxFlag, 0);
    chk(txErr == 1'b0, "R7 error cleared", txErr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; masterMode = 1'b1; cpol = 1'b0; cpha = 1'b0;
    lsbFirst = 1'b0; wCode = 4'd7; txWrite = 1'b0; txData = '0; flagClr = 1'b0;
    baudTick = 1'b0; sclkIn = 1'b0; sdiIn = 1'b0; clkLatch = 1'b1; dataLatch = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "reset busy", busy, 0);
    chk(rxFlag == 1'b0, "reset rxFlag", rxFlag, 0);
    chk(txErr == 1'b0, "reset txErr", txErr, 0);
    chk(rxData == 16'h0, "reset rxData", rxData, 0);

    // R10: disabled outputs high, gated by latches, writes ignored
    chk(sdoOut == 1'b1 && sclkOut == 1'b1, "R10 disabled pins high",
        {sclkOut, sdoOut}, 2'b11);
    clkLatch = 1'b0; dataLatch = 1'b0;
    @(negedge clk);
    chk(sdoOut == 1'b0 && sclkOut == 1'b0, "R10 latch gating",
        {sclkOut, sdoOut}, 2'b00);
    clkLatch = 1'b1; dataLatch = 1'b1;
    txWrite = 1'b1; txData = 16'h00FF;
    @(negedge clk);
    txWrite = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R10 write ignored while disabled", busy, 0);

    enable = 1'b1;
    setup(1'b1, 1'b0, 1'b0, 1'b0, 4'd7);
    chk(sclkOut == 1'b0, "R9 idle clock low", sclkOut, 0);
    masterXfer(16'h00A5, 16'h003C, 1'b0, 1'b0);
    clearFlags();

    setup(1'b1, 1'b1, 1'b1, 1'b1, 4'd4);
    chk(sclkOut == 1'b1, "R9 idle clock high", sclkOut, 1);
    masterXfer(16'h0016, 16'h000B, 1'b0, 1'b0);
    clearFlags();

    setup(1'b1, 1'b0, 1'b1, 1'b0, 4'd15);
    masterXfer(16'hBEEF, 16'h1234, 1'b1, 1'b0);
    clearFlags();

    // R1 code 0 -> 2 bits; R7 completion and clear in the same cycle
    setup(1'b1, 1'b1, 1'b0, 1'b1, 4'd0);
    masterXfer(16'hFFFD, 16'hFFFE, 1'b0, 1'b1);
    chk(rxFlag == 1'b1, "R7 set wins over clear", rxFlag, 1);
    clearFlags();

    setup(1'b0, 1'b0, 1'b0, 1'b0, 4'd7);
    slaveXfer(16'h00C3, 16'h005A);
    clearFlags();

    setup(1'b0, 1'b1, 1'b1, 1'b1, 4'd11);
    slaveXfer(16'h0ABC, 16'h0321);
    clearFlags();

    // R10: gating also applies while enabled
    setup(1'b1, 1'b1, 1'b0, 1'b0, 4'd7);
    dataLatch = 1'b0; clkLatch = 1'b0;
    @(negedge clk);
    chk(sdoOut == 1'b0 && sclkOut == 1'b0, "R10 latch gating enabled",
        {sclkOut, sdoOut}, 2'b00);
    dataLatch = 1'b1; clkLatch = 1'b1;
    @(negedge clk);
    chk(sclkOut == 1'b1, "R10 clock follows internal when latch high", sclkOut, 1);

    chk(expQ.size() == 0, "R6 all results seen", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule